// File: doc/BRIEF.md
# Debug Port Memory Streamer

This block is the memory-access and bus-handoff slave of an on-chip debug port. It is used while the processor core is halted. A debug master issues single register accesses, and each is answered by a one-cycle done pulse. Most registers hold plain debug state: a program-counter copy, a base page and a control byte. One register address is a streaming window into memory. Each read of that address fetches the byte at the address formed from the program counter. The counter then advances, so the master can drain any number of consecutive bytes by reading the same address over and over.

The fetch address depends on the addressing mode. In the 16-bit compatibility mode the address is the base page in the upper byte and the low 16 counter bits below it. In the 24-bit linear mode the whole counter is the address. The block also settles requests from an external bus master. When the control byte enables it, a request is granted only between debug operations. Grant is signalled on an active-low acknowledge output. While the grant lasts, no memory fetch is started. A read-only status register reports the enable and the grant.

Top module: `dbg_mem_streamer`

## Requirements
- R1: After reset the program counter, base page and control byte are 0, the status register reads 0x00, `bus_ack_n` is 1 and `mem_req` and `dbg_done` are 0. An asserted reset in the middle of a grant withdraws the grant.
- R2: An access is taken on a clock edge where `dbg_req` is 1 and no access is in progress. For any register other than the memory window, `dbg_done` pulses for one cycle after the next edge. Writes are applied on that edge. Write accesses return 0.
- R3: A read of address 0x20 issues exactly one single-cycle `mem_req` and returns `mem_rdata` from the `mem_valid` cycle with the done pulse. Reading 0x20 again streams consecutive bytes.
- R4: With control bit 0 clear (compatibility mode) the fetch address is {base, PC[15:0]}.
- R5: With control bit 0 set (linear mode) the fetch address is PC[23:0] and the base page has no effect.
- R6: The program counter increments once per memory-window read. In compatibility mode the low 16 bits wrap and PC[23:16] and the base stay unchanged. In linear mode all 24 bits wrap.
- R7: Registers: PC bytes at 0x10 (bits 7:0), 0x11 (15:8) and 0x12 (23:16), base at 0x13, control at 0x14 (bit 0 linear mode, bit 1 bus-grant enable, other bits read 0). Status at 0x17 is bit 7 enable, bit 6 grant, bits 5:0 zero. Writes to 0x17 change nothing.
- R8: While the enable bit is 0, `bus_req` is ignored and `bus_ack_n` stays 1. Clearing the enable during a grant withdraws it on the following edge.
- R9: With the enable set, a held `bus_req` drives `bus_ack_n` low one edge after the block is idle with no access being taken. A request that arrives during an access is granted on the edge after that access's done edge.
- R10: While the grant is held, no `mem_req` is issued. A pending memory-window read waits and completes after release.
- R11: Dropping `bus_req` during a grant raises `bus_ack_n` after the next edge, and status bit 6 reads 0 again.
- R12: Reads of unmapped addresses return 0. Writes to unmapped addresses have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req | input | 1 | Debug access request, taken when idle |
| dbg_we | input | 1 | 1 = write access, 0 = read access |
| dbg_addr | input | RA_W (8) | Debug register address |
| dbg_wdata | input | DATA_W (8) | Write data |
| dbg_done | output | 1 | One-cycle access completion pulse |
| dbg_rdata | output | DATA_W (8) | Read data, valid with `dbg_done` |
| mem_req | output | 1 | One-cycle memory fetch request |
| mem_addr | output | PC_W (24) | Fetch address, valid with `mem_req` |
| mem_valid | input | 1 | Memory data valid |
| mem_rdata | input | DATA_W (8) | Memory read data |
| bus_req | input | 1 | External bus request, active high |
| bus_ack_n | output | 1 | External bus acknowledge, active low |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 24-bit counter split as a 16-bit offset under an 8-bit base, and the linear-mode variant compiled in. With these values both counter wraps can be reached in a few accesses: the 16-bit wrap that must leave the upper byte and base alone, and the full 24-bit wrap. Both addressing modes can be exercised against the same memory pattern. The memory model answers two cycles after a request, so a bus request can land inside an open fetch. This tests that the grant waits for the operation boundary.

// File: rtl/dbgms_pkg.sv
package dbgms_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_REG   = 2'd1,
      SQ_FETCH = 2'd2,
      SQ_MEM   = 2'd3
   } sq_state_e;

   localparam int CTRL_LINEAR_BIT = 0;
   localparam int CTRL_ACKEN_BIT  = 1;

endpackage

// File: rtl/dbgms_addr_gen.sv
module dbgms_addr_gen #(
   parameter int PC_W       = 24,
   parameter int CMP_W      = 16,
   parameter bit HAS_LINEAR = 1'b1
) (
   input  logic [PC_W-1:0]       pc,
   input  logic [PC_W-CMP_W-1:0] base,
   input  logic                  linear,
   output logic [PC_W-1:0]       fetch_addr,
   output logic [PC_W-1:0]       pc_next
);
   localparam int BASE_W = PC_W - CMP_W;

   logic [PC_W-1:0]  compat_addr;
   logic [PC_W-1:0]  compat_next;
   logic [CMP_W-1:0] low_inc;

   assign low_inc     = pc[CMP_W-1:0] + CMP_W'(1);
   assign compat_addr = {base, pc[CMP_W-1:0]};
   assign compat_next = {pc[PC_W-1:CMP_W], low_inc};

   generate
      if (HAS_LINEAR) begin : g_dual_mode
         assign fetch_addr = linear ? pc : compat_addr;
         assign pc_next    = linear ? (pc + PC_W'(1)) : compat_next;
      end else begin : g_compat_only
         logic unused_linear;
         assign unused_linear = linear;
         assign fetch_addr    = compat_addr;
         assign pc_next       = compat_next;
      end
      if (BASE_W < 1) begin : g_bad_base
         $error("dbgms_addr_gen: base page must be at least one bit wide");
      end
   endgenerate

endmodule

// File: rtl/dbgms_regs.sv
module dbgms_regs
   import dbgms_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int PC_W       = 24,
   parameter int CMP_W      = 16,
   parameter int RA_W       = 8,
   parameter int PC_ADDR0   = 'h10,
   parameter int BASE_ADDR  = 'h13,
   parameter int CTRL_ADDR  = 'h14,
   parameter int STAT_ADDR  = 'h17,
   parameter bit HAS_LINEAR = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [RA_W-1:0]       acc_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  pc_step,
   input  logic [PC_W-1:0]       pc_next,
   input  logic                  granted,
   output logic [PC_W-1:0]       pc,
   output logic [PC_W-CMP_W-1:0] base,
   output logic                  linear,
   output logic                  ack_en,
   output logic [DATA_W-1:0]     rd_data
);
   localparam int PC_BYTES = PC_W / DATA_W;
   localparam int BASE_W   = PC_W - CMP_W;

   logic [PC_BYTES-1:0] pc_hit;
   logic                base_hit;
   logic                ctrl_hit;
   logic                stat_hit;

   genvar g;
   generate
      for (g = 0; g < PC_BYTES; g++) begin : g_pc_hit
         assign pc_hit[g] = (acc_addr == RA_W'(PC_ADDR0 + g));
      end
   endgenerate

   assign base_hit = (acc_addr == RA_W'(BASE_ADDR));
   assign ctrl_hit = (acc_addr == RA_W'(CTRL_ADDR));
   assign stat_hit = (acc_addr == RA_W'(STAT_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (pc_step) begin
         pc <= pc_next;
      end else if (wr_en) begin
         for (int i = 0; i < PC_BYTES; i++) begin
            if (pc_hit[i]) pc[i*DATA_W +: DATA_W] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base   <= '0;
         ack_en <= 1'b0;
      end else if (wr_en) begin
         if (base_hit) base <= wr_data[BASE_W-1:0];
         if (ctrl_hit) ack_en <= wr_data[CTRL_ACKEN_BIT];
      end
   end

   generate
      if (HAS_LINEAR) begin : g_mode_flop
         always_ff @(posedge clk) begin
            if (!rst_n)                linear <= 1'b0;
            else if (wr_en && ctrl_hit) linear <= wr_data[CTRL_LINEAR_BIT];
         end
      end else begin : g_mode_fixed
         assign linear = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < PC_BYTES; i++) begin
         if (pc_hit[i]) rd_data = pc[i*DATA_W +: DATA_W];
      end
      if (base_hit) rd_data = DATA_W'(base);
      if (ctrl_hit) begin
         rd_data[CTRL_LINEAR_BIT] = linear;
         rd_data[CTRL_ACKEN_BIT]  = ack_en;
      end
      if (stat_hit) begin
         rd_data[DATA_W-1] = ack_en;
         rd_data[DATA_W-2] = granted;
      end
   end

   AST_COMPAT_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_step && !linear) |=> (pc[PC_W-1:CMP_W] == $past(pc[PC_W-1:CMP_W])) && $stable(base))
      else $error("upper counter bits or base moved on a compatibility step"); // R6

   AST_STEP_MOVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
      pc_step |=> !$stable(pc))
      else $error("counter did not advance on a memory-window read"); // R6

endmodule

// File: rtl/dbgms_arb.sv
module dbgms_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req,
   input  logic ack_en,
   input  logic seq_idle,
   input  logic dbg_req,
   output logic granted
);
   logic may_grant;

   assign may_grant = ack_en && bus_req && seq_idle && !dbg_req;

   always_ff @(posedge clk) begin
      if (!rst_n)       granted <= 1'b0;
      else if (granted) granted <= ack_en && bus_req;
      else              granted <= may_grant;
   end

   AST_DISABLED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_en |=> !granted)
      else $error("grant held while enable is clear"); // R8

   AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(granted) |-> $past(seq_idle && !dbg_req))
      else $error("grant taken inside a debug operation"); // R9

   AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (granted && !bus_req) |=> !granted)
      else $error("grant outlived its request"); // R11

endmodule

// File: rtl/dbgms_seq.sv
module dbgms_seq
   import dbgms_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PC_W     = 24,
   parameter int RA_W     = 8,
   parameter int MEM_ADDR = 'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_req,
   input  logic              dbg_we,
   input  logic [RA_W-1:0]   dbg_addr,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic              dbg_done,
   output logic [DATA_W-1:0] dbg_rdata,
   output logic [RA_W-1:0]   op_addr,
   output logic [DATA_W-1:0] op_wdata,
   output logic              reg_wr,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic              granted,
   input  logic [PC_W-1:0]   fetch_addr,
   output logic              mem_req,
   output logic [PC_W-1:0]   mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pc_step,
   output logic              seq_idle
);
   sq_state_e state;
   logic      op_we;
   logic      is_window;

   assign is_window = !dbg_we && (dbg_addr == RA_W'(MEM_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         op_we     <= 1'b0;
         op_addr   <= '0;
         op_wdata  <= '0;
         dbg_done  <= 1'b0;
         dbg_rdata <= '0;
         mem_req   <= 1'b0;
         mem_addr  <= '0;
      end else begin
         dbg_done <= 1'b0;
         mem_req  <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (dbg_req) begin
                  op_we    <= dbg_we;
                  op_addr  <= dbg_addr;
                  op_wdata <= dbg_wdata;
                  state    <= is_window ? SQ_FETCH : SQ_REG;
               end
            end
            SQ_REG: begin
               dbg_done  <= 1'b1;
               dbg_rdata <= op_we ? '0 : reg_rdata;
               state     <= SQ_IDLE;
            end
            SQ_FETCH: begin
               if (!granted) begin
                  mem_req  <= 1'b1;
                  mem_addr <= fetch_addr;
                  state    <= SQ_MEM;
               end
            end
            SQ_MEM: begin
               if (mem_valid) begin
                  dbg_done  <= 1'b1;
                  dbg_rdata <= mem_rdata;
                  state     <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign reg_wr   = (state == SQ_REG) && op_we;
   assign pc_step  = (state == SQ_MEM) && mem_valid;
   assign seq_idle = (state == SQ_IDLE);

   AST_NO_FETCH_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !granted)
      else $error("memory fetch issued while bus is handed off"); // R10

   AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req)
      else $error("fetch request longer than one cycle"); // R3

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_done |=> !dbg_done)
      else $error("done held for more than one cycle"); // R2

endmodule

// File: rtl/dbg_mem_streamer.sv
module dbg_mem_streamer #(
   parameter int DATA_W     = 8,
   parameter int PC_W       = 24,
   parameter int CMP_W      = 16,
   parameter int RA_W       = 8,
   parameter int PC_ADDR0   = 'h10,
   parameter int BASE_ADDR  = 'h13,
   parameter int CTRL_ADDR  = 'h14,
   parameter int STAT_ADDR  = 'h17,
   parameter int MEM_ADDR   = 'h20,
   parameter bit HAS_LINEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_req,
   input  logic              dbg_we,
   input  logic [RA_W-1:0]   dbg_addr,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic              dbg_done,
   output logic [DATA_W-1:0] dbg_rdata,
   output logic              mem_req,
   output logic [PC_W-1:0]   mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              bus_req,
   output logic              bus_ack_n
);
   localparam int PC_BYTES = PC_W / DATA_W;
   localparam int PC_LAST  = PC_ADDR0 + PC_BYTES - 1;
   localparam int BASE_W   = PC_W - CMP_W;

   generate
      if (PC_W % DATA_W != 0) begin : g_chk_pc_div
         $error("dbg_mem_streamer: counter width must be whole data bytes");
      end
      if (CMP_W < 1 || CMP_W >= PC_W) begin : g_chk_cmp
         $error("dbg_mem_streamer: compatibility offset must be narrower than the counter");
      end
      if (BASE_W > DATA_W) begin : g_chk_base
         $error("dbg_mem_streamer: base page must fit one data word");
      end
      if (DATA_W < 2) begin : g_chk_data
         $error("dbg_mem_streamer: status needs at least two data bits");
      end
      if (PC_LAST >= (1 << RA_W)) begin : g_chk_space
         $error("dbg_mem_streamer: counter bytes exceed the register space");
      end
      if ((BASE_ADDR >= PC_ADDR0 && BASE_ADDR <= PC_LAST) ||
          (CTRL_ADDR >= PC_ADDR0 && CTRL_ADDR <= PC_LAST) ||
          (STAT_ADDR >= PC_ADDR0 && STAT_ADDR <= PC_LAST) ||
          (MEM_ADDR  >= PC_ADDR0 && MEM_ADDR  <= PC_LAST)) begin : g_chk_pc_overlap
         $error("dbg_mem_streamer: a register overlaps the counter bytes");
      end
      if (BASE_ADDR == CTRL_ADDR || BASE_ADDR == STAT_ADDR || BASE_ADDR == MEM_ADDR ||
          CTRL_ADDR == STAT_ADDR || CTRL_ADDR == MEM_ADDR || STAT_ADDR == MEM_ADDR) begin : g_chk_unique
         $error("dbg_mem_streamer: register addresses must be distinct");
      end
   endgenerate

   logic [RA_W-1:0]   op_addr;
   logic [DATA_W-1:0] op_wdata;
   logic              reg_wr;
   logic [DATA_W-1:0] reg_rdata;
   logic              granted;
   logic              seq_idle;
   logic              pc_step;
   logic [PC_W-1:0]   pc;
   logic [PC_W-1:0]   pc_next;
   logic [PC_W-1:0]   fetch_addr;
   logic [BASE_W-1:0] base;
   logic              linear;
   logic              ack_en;

   dbgms_seq #(
      .DATA_W(DATA_W), .PC_W(PC_W), .RA_W(RA_W), .MEM_ADDR(MEM_ADDR)
   ) seq_i (
      .clk(clk), .rst_n(rst_n),
      .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
      .dbg_done(dbg_done), .dbg_rdata(dbg_rdata),
      .op_addr(op_addr), .op_wdata(op_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
      .granted(granted), .fetch_addr(fetch_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .pc_step(pc_step), .seq_idle(seq_idle)
   );

   dbgms_regs #(
      .DATA_W(DATA_W), .PC_W(PC_W), .CMP_W(CMP_W), .RA_W(RA_W),
      .PC_ADDR0(PC_ADDR0), .BASE_ADDR(BASE_ADDR), .CTRL_ADDR(CTRL_ADDR),
      .STAT_ADDR(STAT_ADDR), .HAS_LINEAR(HAS_LINEAR)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr), .acc_addr(op_addr), .wr_data(op_wdata),
      .pc_step(pc_step), .pc_next(pc_next), .granted(granted),
      .pc(pc), .base(base), .linear(linear), .ack_en(ack_en), .rd_data(reg_rdata)
   );

   dbgms_addr_gen #(
      .PC_W(PC_W), .CMP_W(CMP_W), .HAS_LINEAR(HAS_LINEAR)
   ) addr_i (
      .pc(pc), .base(base), .linear(linear),
      .fetch_addr(fetch_addr), .pc_next(pc_next)
   );

   dbgms_arb arb_i (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .ack_en(ack_en), .seq_idle(seq_idle), .dbg_req(dbg_req),
      .granted(granted)
   );

   assign bus_ack_n = ~granted;

   AST_FETCH_ADDR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !$past(linear)) |-> (mem_addr[CMP_W-1:0] == $past(pc[CMP_W-1:0])))
      else $error("compatibility fetch offset differs from counter"); // R4

endmodule

// File: tb/dbg_mem_streamer_tb_top.sv
`timescale 1ns/1ps
module dbg_mem_streamer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_req = 1'b0;
   logic        dbg_we = 1'b0;
   logic [7:0]  dbg_addr = '0;
   logic [7:0]  dbg_wdata = '0;
   logic        dbg_done;
   logic [7:0]  dbg_rdata;
   logic        mem_req;
   logic [23:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        bus_req = 1'b0;
   logic        bus_ack_n;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dbg_mem_streamer dut_i (
      .clk(clk), .rst_n(rst_n),
      .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
      .dbg_done(dbg_done), .dbg_rdata(dbg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .bus_req(bus_req), .bus_ack_n(bus_ack_n)
   );

   function automatic logic [7:0] pat(input logic [23:0] a);
      return a[7:0] ^ (a[15:8] + 8'h3C) ^ {a[19:16], a[23:20]};
   endfunction

   // memory model: answers two edges after the request
   logic        mstage = 1'b0;
   logic [23:0] mstage_addr = '0;
   logic [23:0] last_fetch = '0;
   int          fetch_cnt = 0;
   always @(posedge clk) begin
      mem_valid <= 1'b0;
      mstage    <= mem_req;
      if (mem_req) begin
         mstage_addr <= mem_addr;
         last_fetch  <= mem_addr;
         fetch_cnt   <= fetch_cnt + 1;
      end
      if (mstage) begin
         mem_valid <= 1'b1;
         mem_rdata <= pat(mstage_addr);
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic start_op(input logic we, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      dbg_req = 1'b1; dbg_we = we; dbg_addr = a; dbg_wdata = d;
      @(negedge clk);
      dbg_req = 1'b0;
   endtask

   task automatic wait_done(output logic [7:0] rd);
      int k = 0;
      while (!dbg_done && k < 60) begin
         @(negedge clk);
         k++;
      end
      if (!dbg_done) chk("R2 done timeout", 0, 1);
      rd = dbg_rdata;
   endtask

   task automatic op(input logic we, input logic [7:0] a, input logic [7:0] d, output logic [7:0] rd);
      start_op(we, a, d);
      wait_done(rd);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] rd;
      op(1'b1, a, d, rd);
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] rd;
      op(1'b0, a, 8'h00, rd);
      chk(tag, rd, exp);
   endtask

   task automatic set_pc(input logic [23:0] p);
      wr(8'h10, p[7:0]);
      wr(8'h11, p[15:8]);
      wr(8'h12, p[23:16]);
   endtask

   task automatic mem_rd(input string tag, input logic [23:0] exp_addr);
      logic [7:0] rd;
      op(1'b0, 8'h20, 8'h00, rd);
      chk({tag, " addr"}, last_fetch, exp_addr);
      chk({tag, " data"}, rd, pat(exp_addr));
   endtask

   // {we, addr, wdata, expected read}
   localparam logic [24:0] VEC [18] = '{
      {1'b1, 8'h10, 8'h34, 8'h00},
      {1'b1, 8'h11, 8'h12, 8'h00},
      {1'b1, 8'h12, 8'h00, 8'h00},
      {1'b1, 8'h13, 8'h7E, 8'h00},
      {1'b1, 8'h14, 8'hFF, 8'h00},
      {1'b0, 8'h10, 8'h00, 8'h34},
      {1'b0, 8'h11, 8'h00, 8'h12},
      {1'b0, 8'h12, 8'h00, 8'h00},
      {1'b0, 8'h13, 8'h00, 8'h7E},
      {1'b0, 8'h14, 8'h00, 8'h03},
      {1'b0, 8'h17, 8'h00, 8'h80},
      {1'b0, 8'h30, 8'h00, 8'h00},
      {1'b1, 8'h14, 8'h00, 8'h00},
      {1'b0, 8'h17, 8'h00, 8'h00},
      {1'b1, 8'h17, 8'hFF, 8'h00},
      {1'b0, 8'h17, 8'h00, 8'h00},
      {1'b1, 8'h40, 8'h55, 8'h00},
      {1'b0, 8'h10, 8'h00, 8'h34}
   };

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      logic       held;
      int         fc0;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 ack_n in reset", bus_ack_n, 1'b1);
      chk("R1 mem_req in reset", mem_req, 1'b0);
      chk("R1 done in reset", dbg_done, 1'b0);
      rst_n = 1'b1;
      rd_chk("R1 pc low after reset", 8'h10, 8'h00);
      rd_chk("R1 status after reset", 8'h17, 8'h00);

      // R2 R7 R12: register table
      for (int i = 0; i < 18; i++) begin
         op(VEC[i][24], VEC[i][23:16], VEC[i][15:8], rd);
         if (VEC[i][24]) chk($sformatf("R2 write returns zero vec %0d", i), rd, 8'h00);
         else            chk($sformatf("R7 R12 readback vec %0d", i), rd, VEC[i][7:0]);
      end
      rd_chk("R12 base untouched by unmapped write", 8'h13, 8'h7E);

      // R3 R4 R6: compatibility streaming
      set_pc(24'h001234);
      mem_rd("R3 R4 stream 0", 24'h7E1234);
      mem_rd("R3 R4 stream 1", 24'h7E1235);
      mem_rd("R3 R4 stream 2", 24'h7E1236);
      rd_chk("R6 pc after three reads", 8'h10, 8'h37);

      // R6: compatibility wrap
      wr(8'h13, 8'hAB);
      set_pc(24'h12FFFF);
      mem_rd("R4 wrap edge", 24'hABFFFF);
      rd_chk("R6 compat wrap low", 8'h10, 8'h00);
      rd_chk("R6 compat wrap mid", 8'h11, 8'h00);
      rd_chk("R6 compat wrap upper held", 8'h12, 8'h12);
      rd_chk("R6 compat base held", 8'h13, 8'hAB);
      mem_rd("R6 after compat wrap", 24'hAB0000);

      // R5 R6: linear mode
      wr(8'h14, 8'h01);
      set_pc(24'h01FFFF);
      mem_rd("R5 linear ignores base", 24'h01FFFF);
      mem_rd("R5 R6 linear carry", 24'h020000);
      set_pc(24'hFFFFFF);
      mem_rd("R5 linear top", 24'hFFFFFF);
      rd_chk("R6 linear wrap low", 8'h10, 8'h00);
      rd_chk("R6 linear wrap upper", 8'h12, 8'h00);
      mem_rd("R6 after linear wrap", 24'h000000);

      // R8: disabled requests ignored
      wr(8'h14, 8'h00);
      @(negedge clk);
      bus_req = 1'b1;
      held = 1'b1;
      repeat (5) begin
         @(negedge clk);
         if (bus_ack_n !== 1'b1) held = 1'b0;
      end
      chk("R8 ack stays high while disabled", held, 1'b1);
      rd_chk("R8 status grant clear while disabled", 8'h17, 8'h00);
      bus_req = 1'b0;

      // R9 R7: grant when idle
      wr(8'h14, 8'h02);
      wr(8'h13, 8'h11);
      set_pc(24'h004000);
      @(negedge clk);
      bus_req = 1'b1;
      @(negedge clk);
      chk("R9 grant one edge after idle request", bus_ack_n, 1'b0);
      rd_chk("R7 status enable and grant", 8'h17, 8'hC0);

      // R10 R11: window read held off during grant
      fc0 = fetch_cnt;
      start_op(1'b0, 8'h20, 8'h00);
      held = 1'b1;
      repeat (8) begin
         @(negedge clk);
         if (dbg_done !== 1'b0) held = 1'b0;
      end
      chk("R10 no done while granted", held, 1'b1);
      chk("R10 no fetch while granted", fetch_cnt, fc0);
      bus_req = 1'b0;
      @(negedge clk);
      chk("R11 ack high after release", bus_ack_n, 1'b1);
      wait_done(rd);
      chk("R10 deferred fetch addr", last_fetch, 24'h114000);
      chk("R10 deferred fetch data", rd, pat(24'h114000));
      rd_chk("R11 status after release", 8'h17, 8'h80);

      // R9: request during an open fetch waits for the boundary
      start_op(1'b0, 8'h20, 8'h00);
      bus_req = 1'b1;
      held = 1'b1;
      while (!dbg_done) begin
         if (bus_ack_n !== 1'b1) held = 1'b0;
         @(negedge clk);
      end
      chk("R9 no grant inside operation", held, 1'b1);
      chk("R9 boundary fetch data", dbg_rdata, pat(24'h114001));
      @(negedge clk);
      chk("R9 grant after done edge", bus_ack_n, 1'b0);

      // R8: clearing the enable withdraws the grant
      start_op(1'b1, 8'h14, 8'h00);
      wait_done(rd);
      @(negedge clk);
      chk("R8 grant withdrawn by enable clear", bus_ack_n, 1'b1);

      // R1: reset during a grant
      wr(8'h14, 8'h02);
      repeat (2) @(negedge clk);
      chk("R1 grant before reset", bus_ack_n, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset drops grant", bus_ack_n, 1'b1);
      bus_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1 status after mid-run reset", 8'h17, 8'h00);
      rd_chk("R1 pc after mid-run reset", 8'h11, 8'h00);
      rd_chk("R1 base after mid-run reset", 8'h13, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule